// File: doc/BRIEF.md
# Fixed-Latency Single/Double Length Shifter

This block shifts one 36-bit word, or a 72-bit quantity made of two words, in one of five shift modes or in a normalizing mode. The result is registered, so every operation takes exactly one clock. The shift count does not change the latency. The upper word is the more significant half of the 72-bit quantity. In single-length operations only the lower word takes part.

The normalizing mode ignores the count input. It rotates the operand left until its two most significant bits differ. It then reports the rotated value and the number of positions rotated. An operand whose bits are all equal cannot be normalized. For such an operand the block stops one short of a full turn and raises a flag.

Counts beyond 72 and the two unused mode codes do not produce undefined data. They give an all-zero result with an error flag set.

Top module: `dual_len_shifter`

## Requirements
- R1: With `dbl_i`=0 the operand is `lo_i` (36 bits), the result appears on `lo_o`, and `hi_o` reads zero.
- R2: With `dbl_i`=1 the operand is {`hi_i`,`lo_i`} (72 bits, `hi_i` more significant) and the result is split the same way onto `hi_o`,`lo_o`.
- R3: Mode 0 rotates right and mode 1 rotates left. Bits leaving one end enter the other, so the effective count is the count modulo the operand width.
- R4: Mode 2 shifts right and mode 3 shifts left, filling with zeros. A count of at least the operand width gives zero.
- R5: Mode 4 shifts right and fills the top with copies of the original most significant bit. A count of at least the width gives all sign copies.
- R6: Mode codes 6 and 7 are reserved. They give a zero result with `undef_o`=1.
- R7: In modes 0 to 4, a count above 72 gives a zero result with `undef_o`=1. Counts 0 to 72 leave `undef_o`=0.
- R8: Mode 5 ignores `cnt_i`. It rotates left by the smallest n for which the two top bits of the result differ, and puts n on `norm_cnt_o`.
- R9: In mode 5, an operand with all bits equal returns unchanged, with `norm_cnt_o` = width-1 and `flat_o`=1.
- R10: `done_o` is high exactly in the cycle after a cycle with `start_i` high, whatever the count. The outputs change only then and hold otherwise.
- R11: While `rst_ni` is low, all outputs are zero.
- R12: In every mode other than 5, `norm_cnt_o` and `flat_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one operation this cycle |
| dbl_i | input | 1 | 1 selects the 72-bit operand |
| mode_i | input | 3 | Operation code (see R3 to R8) |
| cnt_i | input | 7 | Shift count |
| hi_i | input | 36 | Upper operand word |
| lo_i | input | 36 | Lower operand word |
| hi_o | output | 36 | Upper result word |
| lo_o | output | 36 | Lower result word |
| norm_cnt_o | output | 7 | Positions rotated in mode 5 |
| flat_o | output | 1 | Mode 5 operand had all bits equal |
| undef_o | output | 1 | Count or mode code was out of range |
| done_o | output | 1 | Result valid pulse |

## Verification
The output register can present one result while it captures the next one in the same cycle. The bench provokes this by issuing starts back to back, each with a different width, mode and count. A wrong capture or a stretched done pulse then shows up against the neighbouring operation. Idle gaps between bursts show whether the held result stays put.

Each cycle is compared with a behavioural model that shifts one bit at a time. The comparison dwells on the count edges 35 to 37, 71 to 73 and 127, and on normalizing operands that need zero or width-2 rotations, or that are flat.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    M_ROR   = 3'd0,
    M_ROL   = 3'd1,
    M_LSR   = 3'd2,
    M_LSL   = 3'd3,
    M_ASR   = 3'd4,
    M_SCALE = 3'd5,
    M_RSV6  = 3'd6,
    M_RSV7  = 3'd7
  } shf_mode_e;

  typedef enum logic [1:0] {
    F_ZERO = 2'd0,
    F_SIGN = 2'd1,
    F_ROT  = 2'd2
  } fill_e;
endpackage

// File: rtl/shf_norm.sv
// Counts bits below the MSB that equal it, stopping at the first mismatch.
module shf_norm #(
  parameter int unsigned W  = 36,
  parameter int unsigned CW = 7
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o,
  output logic          flat_o
);
  logic run;

  always_comb begin
    cnt_o = '0;
    run   = 1'b1;
    for (int i = W - 2; i >= 0; i--) begin
      if (run && (d_i[i] == d_i[W-1])) cnt_o = cnt_o + CW'(1);
      else                             run   = 1'b0;
    end
  end

  assign flat_o = (cnt_o == CW'(W - 1));
endmodule

// File: rtl/shf_barrel.sv
// Log-depth right shifter; left shifts reuse it through bit reversal.
module shf_barrel import shf_pkg::*; #(
  parameter int unsigned W  = 36,
  parameter int unsigned CW = 7
) (
  input  logic [W-1:0]  d_i,
  input  logic [CW-1:0] amt_i,
  input  logic          left_i,
  input  fill_e         fill_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0]       rev_in, rev_out, src;
  logic [CW-1:0]      eff;
  logic               fbit;
  logic               rot;
  logic [CW:0][W-1:0] st;

  assign rot  = (fill_i == F_ROT);
  assign fbit = (fill_i == F_SIGN) ? d_i[W-1] : 1'b0;
  assign eff  = rot ? CW'(32'(amt_i) % W) : amt_i;

  for (genvar b = 0; b < W; b++) begin : g_rev_in
    assign rev_in[b] = d_i[W-1-b];
  end

  assign src   = left_i ? rev_in : d_i;
  assign st[0] = src;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    if (S < W) begin : g_part
      assign st[k+1] = !eff[k] ? st[k] :
                       rot     ? {st[k][S-1:0], st[k][W-1:S]} :
                                 {{S{fbit}}, st[k][W-1:S]};
    end else begin : g_full
      assign st[k+1] = eff[k] ? {W{fbit}} : st[k];
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_rev_out
    assign rev_out[b] = st[CW][W-1-b];
  end

  assign q_o = left_i ? rev_out : st[CW];
endmodule

// File: rtl/shf_lane.sv
// One operand width: mode decode, normalize count and barrel.
module shf_lane import shf_pkg::*; #(
  parameter int unsigned W  = 36,
  parameter int unsigned CW = 7
) (
  input  logic [W-1:0]  d_i,
  input  shf_mode_e     mode_i,
  input  logic [CW-1:0] cnt_i,
  output logic [W-1:0]  q_o,
  output logic [CW-1:0] ncnt_o,
  output logic          flat_o
);
  logic [CW-1:0] ncnt;
  logic          nflat;
  logic          scale;
  logic          left;
  fill_e         fill;
  logic [CW-1:0] amt;

  shf_norm #(.W(W), .CW(CW)) u_norm (
    .d_i   (d_i),
    .cnt_o (ncnt),
    .flat_o(nflat)
  );

  always_comb begin
    scale = (mode_i == M_SCALE);
    left  = (mode_i == M_ROL) || (mode_i == M_LSL) || scale;
    unique case (mode_i)
      M_ROR, M_ROL, M_SCALE: fill = F_ROT;
      M_ASR:                 fill = F_SIGN;
      default:               fill = F_ZERO;
    endcase
    amt = scale ? ncnt : cnt_i;
  end

  shf_barrel #(.W(W), .CW(CW)) u_barrel (
    .d_i   (d_i),
    .amt_i (amt),
    .left_i(left),
    .fill_i(fill),
    .q_o   (q_o)
  );

  assign ncnt_o = scale ? ncnt : '0;
  assign flat_o = scale & nflat;
endmodule

// File: rtl/dual_len_shifter.sv
module dual_len_shifter import shf_pkg::*; #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned CNT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dbl_i,
  input  logic [2:0]        mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] lo_o,
  output logic [CNT_W-1:0]  norm_cnt_o,
  output logic              flat_o,
  output logic              undef_o,
  output logic              done_o
);
  localparam int unsigned DBL_W = 2 * WORD_W;
  localparam int unsigned NLANE = 2;

  shf_mode_e                   mode;
  logic [NLANE-1:0][DBL_W-1:0] lane_q;
  logic [NLANE-1:0][CNT_W-1:0] lane_n;
  logic [NLANE-1:0]            lane_f;
  logic                        bad;
  logic [DBL_W-1:0]            res_d;

  assign mode = shf_mode_e'(mode_i);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int unsigned LW = (g == 0) ? WORD_W : DBL_W;
    logic [LW-1:0] q;
    logic [LW-1:0] d;
    if (g == 0) begin : g_single
      assign d = lo_i;
    end else begin : g_double
      assign d = {hi_i, lo_i};
    end
    shf_lane #(.W(LW), .CW(CNT_W)) u_lane (
      .d_i   (d),
      .mode_i(mode),
      .cnt_i (cnt_i),
      .q_o   (q),
      .ncnt_o(lane_n[g]),
      .flat_o(lane_f[g])
    );
    assign lane_q[g] = DBL_W'(q);
  end

  assign bad   = (mode_i > 3'd5) ||
                 ((mode != M_SCALE) && (cnt_i > CNT_W'(DBL_W)));
  assign res_d = bad ? '0 : lane_q[dbl_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o       <= '0;
      lo_o       <= '0;
      norm_cnt_o <= '0;
      flat_o     <= 1'b0;
      undef_o    <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        hi_o       <= res_d[DBL_W-1:WORD_W];
        lo_o       <= res_d[WORD_W-1:0];
        norm_cnt_o <= bad ? '0 : lane_n[dbl_i];
        flat_o     <= !bad && lane_f[dbl_i];
        undef_o    <= bad;
      end
    end
  end

  p_done_after_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(hi_o) && $stable(lo_o) && $stable(norm_cnt_o)));
  p_single_hi_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !dbl_i) |=> (hi_o == '0));
  p_big_cnt_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i <= 3'd4) && (cnt_i > CNT_W'(DBL_W)))
      |=> (undef_o && (hi_o == '0) && (lo_o == '0)));
  p_rsv_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i > 3'd5)) |=> (undef_o && (lo_o == '0)));
  p_norm_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i == 3'd5) && !dbl_i)
      |=> (flat_o || (lo_o[WORD_W-1] != lo_o[WORD_W-2])));
  p_norm_double_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i == 3'd5) && dbl_i)
      |=> (flat_o || (hi_o[WORD_W-1] != hi_o[WORD_W-2])));
  p_no_norm_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (mode_i != 3'd5)) |=> ((norm_cnt_o == '0) && !flat_o));
endmodule

// File: tb/dual_len_shifter_test.sv
`timescale 1ns/1ps
module dual_len_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dbl = 1'b0;
  logic [2:0]  mode = '0;
  logic [6:0]  cnt = '0;
  logic [35:0] hi = '0;
  logic [35:0] lo = '0;
  logic [35:0] hi_o, lo_o;
  logic [6:0]  ncnt_o;
  logic        flat_o, undef_o, done_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dual_len_shifter uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dbl_i(dbl),
    .mode_i(mode), .cnt_i(cnt), .hi_i(hi), .lo_i(lo),
    .hi_o(hi_o), .lo_o(lo_o), .norm_cnt_o(ncnt_o),
    .flat_o(flat_o), .undef_o(undef_o), .done_o(done_o)
  );

  function automatic void ref_op(input logic [2:0] m, input logic d, input int c,
                                 input logic [35:0] h, input logic [35:0] l,
                                 output logic [71:0] q, output logic [6:0] n,
                                 output logic fl, output logic ud);
    int w;
    logic [71:0] v, msk;
    logic b;
    w   = d ? 72 : 36;
    msk = d ? {72{1'b1}} : {36'b0, {36{1'b1}}};
    v   = d ? {h, l} : {36'b0, l};
    n = '0; fl = 1'b0; ud = 1'b0;
    if (m > 3'd5 || (m != 3'd5 && c > 72)) begin
      q = '0; ud = 1'b1;
      return;
    end
    if (m == 3'd5) begin
      int k = 0;
      while (k < w - 1 && v[w-1] == v[w-2]) begin
        b = v[w-1]; v = (v << 1) & msk; v[0] = b; k++;
      end
      n = 7'(k); fl = (k == w - 1);
    end else begin
      for (int i = 0; i < c; i++) begin
        case (m)
          3'd0: begin b = v[0]; v = v >> 1; v[w-1] = b; end
          3'd1: begin b = v[w-1]; v = (v << 1) & msk; v[0] = b; end
          3'd2: v = v >> 1;
          3'd3: v = (v << 1) & msk;
          default: begin b = v[w-1]; v = v >> 1; v[w-1] = b; end
        endcase
      end
    end
    q = v;
  endfunction

  logic [35:0] e_hi, e_lo;
  logic [6:0]  e_n;
  logic        e_fl, e_ud, e_done;
  string       e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_hi <= '0; e_lo <= '0; e_n <= '0; e_fl <= 1'b0; e_ud <= 1'b0; e_done <= 1'b0;
      e_tag <= "R11";
    end else begin
      e_done <= start;
      if (start) begin
        logic [71:0] q; logic [6:0] n; logic fl, ud; string t;
        ref_op(mode, dbl, int'(cnt), hi, lo, q, n, fl, ud);
        e_hi <= q[71:36]; e_lo <= q[35:0]; e_n <= n; e_fl <= fl; e_ud <= ud;
        if (mode > 3'd5)                    t = "R6";
        else if (mode == 3'd5)              t = fl ? "R9" : "R8";
        else if (cnt > 7'd72)               t = "R7";
        else if (mode <= 3'd1)              t = "R3";
        else if (mode <= 3'd3)              t = "R4";
        else                                t = "R5";
        e_tag <= {t, dbl ? "/R2" : "/R1", (mode == 3'd5) ? "" : "/R12"};
      end
    end
  end

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk({e_tag, " hi"}, 72'(hi_o), 72'(e_hi));
    chk({e_tag, " lo"}, 72'(lo_o), 72'(e_lo));
    chk({e_tag, " ncnt"}, 72'(ncnt_o), 72'(e_n));
    chk({e_tag, " flat"}, 72'(flat_o), 72'(e_fl));
    chk({e_tag, " undef"}, 72'(undef_o), 72'(e_ud));
    chk("R10 done", 72'(done_o), 72'(e_done));
  endtask

  task automatic op(input logic s, input logic d, input logic [2:0] m, input logic [6:0] c,
                    input logic [35:0] h, input logic [35:0] l);
    start = s; dbl = d; mode = m; cnt = c; hi = h; lo = l;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cl [10] = '{0, 1, 5, 35, 36, 37, 71, 72, 73, 127};
    logic [35:0] sp [8] = '{36'h0, 36'hFFFFFFFFF, 36'h1, 36'h800000000,
                            36'hC00000000, 36'h400000000, 36'h3FFFFFFFF, 36'hFFF000123};
    @(negedge clk); @(negedge clk);
    // R11: reset state
    chk("R11 hi", 72'(hi_o), 72'd0); chk("R11 lo", 72'(lo_o), 72'd0);
    chk("R11 ncnt", 72'(ncnt_o), 72'd0); chk("R11 flags", 72'({flat_o, undef_o, done_o}), 72'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    // R1..R5, R7: all shift modes, both widths, count edges, back to back
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 5; m++)
        for (int i = 0; i < 10; i++)
          op(1'b1, d[0], 3'(m), 7'(cl[i]), 36'h93C5A0F1E, 36'hA5F0C3E71);
    // R10: idle cycles hold the last result
    repeat (3) op(1'b0, 1'b1, 3'd0, 7'd3, 36'h123456789, 36'h0);
    // R8, R9: normalizing, count input ignored
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b += 3)
          op(1'b1, d[0], 3'd5, 7'(a * 13 + b), sp[a], sp[b]);
    op(1'b1, 1'b1, 3'd5, 7'd0, 36'h0, 36'h1);
    op(1'b1, 1'b1, 3'd5, 7'd0, 36'hFFFFFFFFF, 36'hFFFFFFFFE);
    // R6: reserved codes
    op(1'b1, 1'b0, 3'd6, 7'd4, 36'h123456789, 36'hFEDCBA987);
    op(1'b1, 1'b1, 3'd7, 7'd1, 36'h123456789, 36'hFEDCBA987);
    op(1'b0, 1'b0, 3'd0, 7'd0, 36'h0, 36'h0);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      op(($urandom % 4) != 0, 1'($urandom), 3'($urandom % 8), 7'($urandom),
         36'({$urandom, $urandom}), 36'({$urandom, $urandom}));
    op(1'b0, 1'b0, 3'd0, 7'd0, 36'h0, 36'h0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule